// File: doc/BRIEF.md
# Dual-Port Strobed Parallel Interface

This block provides two byte-wide parallel ports, A and B, between a small microprocessor bus and external peripherals. Each port has a ready output and an active-low strobe input toward the peripheral. The CPU side writes a mode register, an output latch and a per-bit direction register, and reads back the input latch through a small register window. A port can act as an output, an input, a bidirectional port (A only) or a set of individually steered bit lines.

The handshake is a ready/strobe exchange. The port raises ready when it holds data for the peripheral, or when it has room for data from the peripheral. The peripheral pulls its strobe low and lets it go high again, and the rising edge ends the transfer. Strobes pass through a two-stage synchronizer before edge detection. Every finished transfer raises a one-cycle completion pulse for interrupt logic elsewhere.

In bidirectional mode Port A uses both handshake pairs. Its own strobe turns its output drivers on. Port B's strobe captures the Port A pins into the Port A input latch, and Port B's ready shows whether that latch is empty. Port B then runs only as steered bit lines, with no handshake of its own.

Top module: `dual_strobe_pio`

## Requirements
- R1: After reset both ports are in input mode (mode code 1), no pin is driven (pin enables all zero), both ready outputs are high, and a data read returns 0.
- R2: In output mode (code 0) the port drives all pins with its output latch. A CPU write to the data register raises ready, and the next strobe rising edge clears ready and raises one done pulse. A strobe while ready is low is ignored.
- R3: In input mode, a strobe rising edge while the input latch is empty captures the pins, drops ready and raises one done pulse. Further strobes are ignored while the latch is full. A CPU data read returns the latch and raises ready again.
- R4: A strobe held low does not complete a transfer. The transfer completes at the rising edge, and each rising edge counts exactly once however long the strobe was low.
- R5: In bidirectional mode (code 2) the Port A pins are undriven except while Port A's strobe is low, when they carry the output latch. Port A ready shows that the output latch is full, and Port A's strobe rising edge empties the latch and pulses Port A done.
- R6: In bidirectional mode, Port B's strobe rising edge captures the Port A pins into the Port A input latch and pulses Port A done (not Port B done). Port B ready is high while that latch is empty and goes high again after the CPU reads Port A data.
- R7: Port B ignores a mode write of code 2. It ignores a write of code 3 unless Port A is in mode 2. The mode register reads back the code in bits 1:0.
- R8: In bit-control mode (code 3) each pin whose direction bit is 1 is driven from the output latch, and its enable is that direction bit. A data read returns the latch bit for output bits and the pin for input bits. The strobe has no effect and done stays low.
- R9: When Port A leaves mode 2 while Port B is in mode 3, Port B returns to input mode on the next clock.
- R10: Any accepted mode write clears the handshake state, so after the write the output latch counts as empty and the input latch as empty.
- R11: Register window: addr[2] selects the port (0 = A, 1 = B), and addr[1:0] selects data (0), mode (1) or direction (2). Accesses require sel together with wr or rd, and rdata is 0 when no read is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block select from the CPU bus |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| addr | input | 3 | Register address (port, register) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A per-pin drive enable |
| a_stb_n | input | 1 | Port A strobe, active low |
| a_rdy | output | 1 | Port A ready |
| a_done | output | 1 | Port A transfer-complete pulse |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B per-pin drive enable |
| b_stb_n | input | 1 | Port B strobe, active low (serves Port A input in mode 2) |
| b_rdy | output | 1 | Port B ready (Port A input ready in mode 2) |
| b_done | output | 1 | Port B transfer-complete pulse |

## Verification
The assertions check on every cycle that Port B never holds mode 2 and falls back from bit-control mode once Port A leaves bidirectional mode. They also check that a completion clears output ready, that a full input latch keeps ready low until a read, and that done pulses last one cycle and stay quiet in bit-control mode. The bench scenarios are needed to show the data itself: the captured byte, the pin drive window under the Port A strobe, the merged bit-control read, and that a second strobe against a full latch leaves the first byte intact.

// File: rtl/spio_pkg.sv
package spio_pkg;
  typedef enum logic [1:0] {
    M_OUT   = 2'd0,
    M_IN    = 2'd1,
    M_BIDIR = 2'd2,
    M_BITS  = 2'd3
  } pmode_t;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_MODE = 2'd1;
  localparam logic [1:0] REG_DIR  = 2'd2;

  // Mode acceptance: a port without bidirectional capability refuses
  // mode 2, and accepts bit-control only while its peer is bidirectional.
  function automatic logic mode_accept(input logic can_bidir,
                                       input pmode_t req,
                                       input pmode_t peer);
    if (can_bidir) return 1'b1;
    if (req == M_BIDIR) return 1'b0;
    if (req == M_BITS) return peer == M_BIDIR;
    return 1'b1;
  endfunction

  // Ready as seen on the port's own handshake pair.
  function automatic logic ready_of(input pmode_t m,
                                    input logic out_full,
                                    input logic in_full);
    case (m)
      M_OUT:   return out_full;
      M_IN:    return !in_full;
      M_BIDIR: return out_full;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spio_strobe_sync.sv
module spio_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  output logic stb_low,
  output logic stb_rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= stb_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign stb_low  = !s2;
  assign stb_rise = s2 && !s3;
endmodule

// File: rtl/spio_port.sv
module spio_port
  import spio_pkg::*;
#(
  parameter int W = 8,
  parameter bit CAN_BIDIR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_mode,
  input  logic         wr_dir,
  input  logic         rd_data,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic         stb_rise,
  input  logic         stb_low,
  input  logic         alt_rise,
  input  pmode_t       peer_mode,
  output pmode_t       mode,
  output logic [W-1:0] dir,
  output logic [W-1:0] view,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         rdy,
  output logic         alt_rdy,
  output logic         done
);
  logic [W-1:0] out_lat, in_lat;
  logic out_full, in_full;

  function automatic logic [W-1:0] bit_merge(input logic [W-1:0] pins,
                                             input logic [W-1:0] lat,
                                             input logic [W-1:0] d);
    return (pins & ~d) | (lat & d);
  endfunction

  pmode_t req_mode;
  logic   mode_ok, fallback, drives_out, cap_req, cap_ok, put_ok, reads_in;

  assign req_mode   = pmode_t'(wdata[1:0]);
  assign mode_ok    = mode_accept(CAN_BIDIR, req_mode, peer_mode);
  assign fallback   = !CAN_BIDIR && (mode == M_BITS) && (peer_mode != M_BIDIR);
  assign drives_out = (mode == M_OUT) || (mode == M_BIDIR);
  assign reads_in   = (mode == M_IN) || (mode == M_BIDIR);
  assign cap_req    = ((mode == M_IN) && stb_rise) || ((mode == M_BIDIR) && alt_rise);
  assign cap_ok     = cap_req && !in_full;
  assign put_ok     = drives_out && stb_rise && out_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_IN;
      out_full <= 1'b0;
      in_full  <= 1'b0;
    end else if (wr_mode && mode_ok) begin
      mode     <= req_mode;
      out_full <= 1'b0;
      in_full  <= 1'b0;
    end else if (fallback) begin
      mode     <= M_IN;
      out_full <= 1'b0;
      in_full  <= 1'b0;
    end else begin
      if (wr_data && drives_out) out_full <= 1'b1;
      else if (put_ok)           out_full <= 1'b0;
      if (cap_ok)                in_full  <= 1'b1;
      else if (rd_data && reads_in) in_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lat <= '0;
      in_lat  <= '0;
      dir     <= '0;
    end else begin
      if (wr_data) out_lat <= wdata;
      if (cap_ok)  in_lat  <= pin_in;
      if (wr_dir)  dir     <= wdata;
    end
  end

  always_comb begin
    pin_out = out_lat;
    case (mode)
      M_OUT:   begin pin_oe = '1;             view = out_lat; end
      M_IN:    begin pin_oe = '0;             view = in_lat;  end
      M_BIDIR: begin pin_oe = {W{stb_low}};   view = in_lat;  end
      default: begin pin_oe = dir;            view = bit_merge(pin_in, out_lat, dir); end
    endcase
  end

  assign rdy     = ready_of(mode, out_full, in_full);
  assign alt_rdy = (mode == M_BIDIR) && !in_full;
  assign done    = put_ok || cap_ok;
endmodule

// File: rtl/dual_strobe_pio.sv
module dual_strobe_pio
  import spio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr,
  input  logic         rd,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic         a_stb_n,
  output logic         a_rdy,
  output logic         a_done,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic         b_stb_n,
  output logic         b_rdy,
  output logic         b_done
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] stb_n_v, stb_low_v, stb_rise_v;
  assign stb_n_v = {b_stb_n, a_stb_n};

  for (genvar g = 0; g < NPORT; g++) begin : g_sync
    spio_strobe_sync u_sync (
      .clk(clk), .rst_n(rst_n), .stb_n(stb_n_v[g]),
      .stb_low(stb_low_v[g]), .stb_rise(stb_rise_v[g])
    );
  end

  // Named decode strobes, also watched by the checker.
  logic wr_go, rd_go;
  assign wr_go = sel && wr;
  assign rd_go = sel && rd;

  logic a_wr_data, a_wr_mode, a_wr_dir, a_rd_data;
  logic b_wr_data, b_wr_mode, b_wr_dir, b_rd_data;
  assign a_wr_data = wr_go && !addr[2] && (addr[1:0] == REG_DATA);
  assign a_wr_mode = wr_go && !addr[2] && (addr[1:0] == REG_MODE);
  assign a_wr_dir  = wr_go && !addr[2] && (addr[1:0] == REG_DIR);
  assign a_rd_data = rd_go && !addr[2] && (addr[1:0] == REG_DATA);
  assign b_wr_data = wr_go &&  addr[2] && (addr[1:0] == REG_DATA);
  assign b_wr_mode = wr_go &&  addr[2] && (addr[1:0] == REG_MODE);
  assign b_wr_dir  = wr_go &&  addr[2] && (addr[1:0] == REG_DIR);
  assign b_rd_data = rd_go &&  addr[2] && (addr[1:0] == REG_DATA);

  pmode_t a_mode, b_mode;
  logic [W-1:0] a_dir, b_dir, a_view, b_view;
  logic a_alt_rdy, b_alt_rdy, b_rdy_own;
  logic a_rise, b_rise, a_bidir;

  assign a_rise  = stb_rise_v[0];
  assign a_bidir = (a_mode == M_BIDIR);
  // Port B's handshake pair belongs to Port A while A is bidirectional.
  assign b_rise  = stb_rise_v[1] && !a_bidir;

  spio_port #(.W(W), .CAN_BIDIR(1'b1)) u_pa (
    .clk(clk), .rst_n(rst_n),
    .wr_data(a_wr_data), .wr_mode(a_wr_mode), .wr_dir(a_wr_dir), .rd_data(a_rd_data),
    .wdata(wdata), .pin_in(pa_in),
    .stb_rise(a_rise), .stb_low(stb_low_v[0]), .alt_rise(stb_rise_v[1] && a_bidir),
    .peer_mode(b_mode),
    .mode(a_mode), .dir(a_dir), .view(a_view),
    .pin_out(pa_out), .pin_oe(pa_oe),
    .rdy(a_rdy), .alt_rdy(a_alt_rdy), .done(a_done)
  );

  spio_port #(.W(W), .CAN_BIDIR(1'b0)) u_pb (
    .clk(clk), .rst_n(rst_n),
    .wr_data(b_wr_data), .wr_mode(b_wr_mode), .wr_dir(b_wr_dir), .rd_data(b_rd_data),
    .wdata(wdata), .pin_in(pb_in),
    .stb_rise(b_rise), .stb_low(stb_low_v[1] && !a_bidir), .alt_rise(1'b0),
    .peer_mode(a_mode),
    .mode(b_mode), .dir(b_dir), .view(b_view),
    .pin_out(pb_out), .pin_oe(pb_oe),
    .rdy(b_rdy_own), .alt_rdy(b_alt_rdy), .done(b_done)
  );

  // b_alt_rdy is always low (B never enters mode 2); it is folded in harmlessly.
  assign b_rdy = a_bidir ? a_alt_rdy : (b_rdy_own || b_alt_rdy);

  always_comb begin
    rdata = '0;
    if (rd_go) begin
      case ({addr[2], addr[1:0]})
        {1'b0, REG_DATA}: rdata = a_view;
        {1'b0, REG_MODE}: rdata = W'(a_mode);
        {1'b0, REG_DIR}:  rdata = a_dir;
        {1'b1, REG_DATA}: rdata = b_view;
        {1'b1, REG_MODE}: rdata = W'(b_mode);
        {1'b1, REG_DIR}:  rdata = b_dir;
        default:          rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spio_checks.sv
module spio_checks
  import spio_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input pmode_t a_mode,
  input pmode_t b_mode,
  input logic   a_rdy,
  input logic   a_done,
  input logic   b_done,
  input logic   a_rise,
  input logic   a_wr_data,
  input logic   a_wr_mode,
  input logic   a_rd_data
);
  p_b_no_bidir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b_mode != M_BIDIR);

  p_b_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_mode == M_BITS && a_mode != M_BIDIR) |=> (b_mode == M_IN));

  p_rdy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mode == M_OUT && a_rdy && a_rise && !a_wr_data && !a_wr_mode) |=> !a_rdy);

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mode == M_IN && !a_rdy && !a_rd_data && !a_wr_mode) |=> !a_rdy);

  p_a_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_done && a_mode != M_BIDIR) |=> !a_done);

  p_b_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_done |=> !b_done);

  p_bits_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_mode == M_BITS) |-> !b_done);
endmodule

bind dual_strobe_pio spio_checks u_chk (
  .clk(clk), .rst_n(rst_n), .a_mode(a_mode), .b_mode(b_mode),
  .a_rdy(a_rdy), .a_done(a_done), .b_done(b_done), .a_rise(a_rise),
  .a_wr_data(a_wr_data), .a_wr_mode(a_wr_mode), .a_rd_data(a_rd_data)
);

// File: tb/dual_strobe_pio_test.sv
`timescale 1ns/1ps
module dual_strobe_pio_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, pa_in = 0, pa_out, pa_oe, pb_in = 0, pb_out, pb_oe;
  logic a_stb_n = 1, b_stb_n = 1, a_rdy, b_rdy, a_done, b_done;

  int total = 0, bad = 0, a_cnt = 0, b_cnt = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  dual_strobe_pio uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .a_stb_n(a_stb_n), .a_rdy(a_rdy), .a_done(a_done), .pb_in(pb_in),
    .pb_out(pb_out), .pb_oe(pb_oe), .b_stb_n(b_stb_n), .b_rdy(b_rdy), .b_done(b_done)
  );

  always @(posedge clk) begin
    if (rst_n && a_done) a_cnt <= a_cnt + 1;
    if (rst_n && b_done) b_cnt <= b_cnt + 1;
  end

  // {dir, latch, pin, expected read}
  localparam logic [31:0] VEC [4] = '{
    32'hF0A53CAC, 32'h00FF1212, 32'hFF5A005A, 32'h0F817E71
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic pulse_a(input int lowc);
    @(negedge clk); a_stb_n = 0;
    repeat (lowc) @(negedge clk);
    a_stb_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_b(input int lowc);
    @(negedge clk); b_stb_n = 0;
    repeat (lowc) @(negedge clk);
    b_stb_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 rdy", {a_rdy, b_rdy}, 2'b11);
    cpu_rd(3'd1, rv); chk("R1 A mode", rv, 8'd1);
    cpu_rd(3'd0, rv); chk("R1 A data", rv, 8'h00);
    chk("R11 idle rdata", rdata, 8'h00);

    // R2 output mode
    cpu_wr(3'd1, 8'd0);
    chk("R2 pa_oe", pa_oe, 8'hFF);
    chk("R10 rdy after mode", a_rdy, 1'b0);
    cpu_wr(3'd0, 8'h3C);
    chk("R2 pa_out", pa_out, 8'h3C);
    chk("R2 rdy set", a_rdy, 1'b1);
    a0 = a_cnt;
    @(negedge clk); a_stb_n = 0;
    repeat (6) @(negedge clk);
    chk("R4 low holds rdy", a_rdy, 1'b1);
    chk("R4 low no done", a_cnt, a0);
    a_stb_n = 1;
    repeat (4) @(negedge clk);
    chk("R2 rdy cleared", a_rdy, 1'b0);
    chk("R4 one done", a_cnt, a0 + 1);
    pulse_a(2);
    chk("R2 strobe ignored", a_cnt, a0 + 1);

    // R3 input mode
    cpu_wr(3'd1, 8'd1);
    chk("R10 rdy empty", a_rdy, 1'b1);
    pa_in = 8'h96;
    a0 = a_cnt;
    pulse_a(2);
    chk("R3 rdy low", a_rdy, 1'b0);
    chk("R3 done", a_cnt, a0 + 1);
    pa_in = 8'h11;
    pulse_a(2);
    chk("R3 full ignores", a_cnt, a0 + 1);
    cpu_rd(3'd0, rv); chk("R3 data", rv, 8'h96);
    chk("R3 rdy back", a_rdy, 1'b1);

    // R7 Port B mode rules
    cpu_wr(3'd5, 8'd2);
    cpu_rd(3'd5, rv); chk("R7 B rejects 2", rv, 8'd1);
    cpu_wr(3'd5, 8'd3);
    cpu_rd(3'd5, rv); chk("R7 B rejects 3", rv, 8'd1);

    // R5 / R6 bidirectional
    cpu_wr(3'd1, 8'd2);
    chk("R5 tristate", pa_oe, 8'h00);
    cpu_wr(3'd5, 8'd3);
    cpu_rd(3'd5, rv); chk("R7 B accepts 3", rv, 8'd3);
    chk("R6 b_rdy empty", b_rdy, 1'b1);
    cpu_wr(3'd0, 8'h5A);
    chk("R5 rdy full", a_rdy, 1'b1);
    chk("R5 still tristate", pa_oe, 8'h00);
    a0 = a_cnt;
    @(negedge clk); a_stb_n = 0;
    repeat (3) @(negedge clk);
    chk("R5 drive on low", pa_oe, 8'hFF);
    chk("R5 drive value", pa_out, 8'h5A);
    a_stb_n = 1;
    repeat (4) @(negedge clk);
    chk("R5 off after", pa_oe, 8'h00);
    chk("R5 rdy cleared", a_rdy, 1'b0);
    chk("R5 done", a_cnt, a0 + 1);
    pa_in = 8'hC3;
    pulse_b(2);
    chk("R6 b_rdy low", b_rdy, 1'b0);
    chk("R6 A done", a_cnt, a0 + 2);
    chk("R8 no B done", b_cnt, 0);
    cpu_rd(3'd0, rv); chk("R6 data", rv, 8'hC3);
    chk("R6 b_rdy back", b_rdy, 1'b1);

    // R8 Port B bit control
    cpu_wr(3'd6, 8'h0F);
    cpu_wr(3'd4, 8'hA5);
    pb_in = 8'h3C;
    @(negedge clk);
    chk("R8 pb_oe", pb_oe, 8'h0F);
    chk("R8 pb_out", pb_out, 8'hA5);
    cpu_rd(3'd4, rv); chk("R8 B merge", rv, 8'h35);

    // R9 fallback
    cpu_wr(3'd1, 8'd3);
    @(negedge clk);
    cpu_rd(3'd5, rv); chk("R9 B mode", rv, 8'd1);
    chk("R9 pb_oe", pb_oe, 8'h00);

    // R8 table walk on Port A bit control
    for (int i = 0; i < 4; i++) begin
      cpu_wr(3'd2, VEC[i][31:24]);
      cpu_wr(3'd0, VEC[i][23:16]);
      pa_in = VEC[i][15:8];
      @(negedge clk);
      chk("R8 A oe", pa_oe, VEC[i][31:24]);
      cpu_rd(3'd0, rv); chk("R8 A merge", rv, VEC[i][7:0]);
    end
    a0 = a_cnt;
    pulse_a(2);
    chk("R8 A strobe quiet", a_cnt, a0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule